// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block is a watchdog for a system controller. A slow-clock enable, one pulse per slow-clock period sampled in the system clock domain, is divided by a prescaler into a count tick. On every tick a 12-bit down counter decrements. When a tick arrives while the counter already holds zero, the block records an underflow, reloads the counter and, if resets are allowed, raises a reset request for a fixed number of system clocks.

Software sets up the watchdog through a configuration register that accepts only its first write after reset. That register holds the reload value, the window delta, a reset-enable bit, a debug-freeze bit and a disable bit. Software keeps the system alive by writing a keyed restart command. A restart is honoured only when the current count is at or below the delta value. A restart outside that window is refused and flagged. A status register shows the live count and two sticky flags, and reading it clears the flags.

Register map, selected by `bus_addr`: 0 is configuration, 1 is restart command, 2 is status. Configuration fields: reload in [11:0], delta in [23:12], reset-enable in [24], debug-freeze in [25], disable in [26]. Restart command: key in [31:24], restart bit in [0]. Status: underflow flag in [0], window-error flag in [1], live count in [27:16]. All other bits read as zero.

Top module: `wdog_window_top`

## Requirements
- R1: After reset the configuration reads 0x01FFFFFF (reload 0xFFF, delta 0xFFF, reset-enable 1, debug-freeze 0, disable 0). Status reads 0x0FFF0000 and `rst_req` is low.
- R2: Only the first configuration write after reset is stored, and that write also loads the counter with its new reload value. Every later configuration write leaves both the register and the count unchanged.
- R3: The tick occurs once every PRESCALE (default 128) cycles in which `slow_en` is high and the watchdog is running. Cycles with `slow_en` low do not advance the prescaler.
- R4: Each tick decrements the count by one. A tick that finds the count at zero reloads the count from the reload value and sets the underflow flag (status bit 0).
- R5: When reset-enable is 1, an underflow makes `rst_req` high for exactly 4 consecutive system clocks, starting the cycle after the underflow.
- R6: When reset-enable is 0, an underflow sets the underflow flag but `rst_req` stays low.
- R7: While disable is 1 the count does not change, `rst_req` stays low, and restart commands have no effect.
- R8: While debug-freeze is 1 and `dbg_halt_in` is high, the count and the prescaler do not advance.
- R9: A restart command is recognised only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other write to the command address changes nothing.
- R10: A recognised restart reloads the count only when the count is at or below delta; a count equal to delta is accepted. Otherwise the count is kept and the sticky window-error flag (status bit 1) is set. A delta of 0xFFF accepts any count.
- R11: A status read returns the current flags and clears both flags on the same clock. An event in that same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle enable per slow-clock period |
| dbg_halt_in | input | 1 | Debugger halt indication |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 configuration, 1 command, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| rst_req | output | 1 | Reset request pulse |

## Verification
The counter is run in bursts of slow enables whose lengths sit one short of and exactly on a prescaler boundary. This separates correct division from an off-by-one divider. Restarts are tried with a wrong key, with a missing command bit, with the count above delta, with the count equal to delta, and while disabled. These cases show apart a refused restart, an ignored restart and an accepted one. Underflow is reached three times, once each with resets enabled, with resets disabled and with the watchdog disabled. The reset pulse is counted cycle by cycle, so that its length and its absence can both be checked.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W = 12;
    localparam logic [7:0] RESTART_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_CMD  = 2'd1,
        ADDR_STAT = 2'd2
    } wd_addr_e;

    // Packed MSB first: dis[26] halt_en[25] rst_en[24] delta[23:12] reload[11:0]
    typedef struct packed {
        logic             dis;
        logic             halt_en;
        logic             rst_en;
        logic [CNT_W-1:0] delta;
        logic [CNT_W-1:0] reload;
    } wd_mode_t;

    localparam int MODE_W = $bits(wd_mode_t);

    localparam wd_mode_t MODE_DEFAULT = '{
        dis:     1'b0,
        halt_en: 1'b0,
        rst_en:  1'b1,
        delta:   {CNT_W{1'b1}},
        reload:  {CNT_W{1'b1}}
    };

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t pre_q, pre_d;
    logic adv;

    always_comb begin
        pre_d = pre_q;
        adv   = slow_en && run;
        tick  = adv && (pre_q.cnt == LAST);
        if (adv) begin
            if (pre_q.cnt == LAST) pre_d.cnt = '0;
            else                   pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: a frozen prescaler keeps its phase
    assert_frozen_prescaler_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pre_q.cnt));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dis,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [CNT_W-1:0] cfg_delta,
    input  logic             mode_load,
    input  logic [CNT_W-1:0] load_value,
    input  logic             restart_req,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             uflow_evt,
    output logic             winerr_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_q, cnt_d;
    logic restart_ok;
    logic accept;

    always_comb begin
        cnt_d      = cnt_q;
        restart_ok = restart_req && !cfg_dis;
        accept     = restart_ok && (cnt_q.cnt <= cfg_delta);
        winerr_evt = restart_ok && (cnt_q.cnt > cfg_delta);
        uflow_evt  = 1'b0;
        if (mode_load) begin
            cnt_d.cnt = load_value;
        end else if (accept) begin
            cnt_d.cnt = cfg_reload;
        end else if (tick) begin
            if (cnt_q.cnt == '0) begin
                uflow_evt = 1'b1;
                cnt_d.cnt = cfg_reload;
            end else begin
                cnt_d.cnt = cnt_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{cnt: MODE_DEFAULT.reload};
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

    // R4: plain tick steps down by one
    assert_tick_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mode_load && !accept && cnt_q.cnt != '0)
            |=> cnt_q.cnt == $past(cnt_q.cnt) - 1'b1);

    // R7: disabled counter holds
    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dis |=> $stable(cnt_q.cnt));

    // R10: refused restart leaves the count alone
    assert_refused_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (winerr_evt && !tick) |=> $stable(cnt_q.cnt));

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             uflow_evt,
    input  logic             winerr_evt,
    output wd_mode_t         mode,
    output logic             mode_load,
    output logic             restart_req,
    output logic [31:0]      bus_rdata
);
    typedef struct packed {
        wd_mode_t mode;
        logic     locked;
        logic     uf_flag;
        logic     we_flag;
    } regs_t;

    regs_t rq, rd;
    logic  stat_rd;
    logic  unused_wdata;

    assign unused_wdata = ^bus_wdata[23:1];

    always_comb begin
        rd          = rq;
        mode_load   = bus_wr && (bus_addr == ADDR_MODE) && !rq.locked;
        restart_req = bus_wr && (bus_addr == ADDR_CMD)
                      && (bus_wdata[31:24] == RESTART_KEY) && bus_wdata[0];
        stat_rd     = bus_rd && (bus_addr == ADDR_STAT);
        if (mode_load) begin
            rd.mode   = wd_mode_t'(bus_wdata[MODE_W-1:0]);
            rd.locked = 1'b1;
        end
        if (stat_rd) begin
            rd.uf_flag = 1'b0;
            rd.we_flag = 1'b0;
        end
        if (uflow_evt)  rd.uf_flag = 1'b1;
        if (winerr_evt) rd.we_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq <= '{mode: MODE_DEFAULT, locked: 1'b0, uf_flag: 1'b0, we_flag: 1'b0};
        else        rq <= rd;
    end

    always_comb begin
        case (bus_addr)
            ADDR_MODE: bus_rdata = {{(32-MODE_W){1'b0}}, rq.mode};
            ADDR_STAT: bus_rdata = {4'b0, count, 14'b0, rq.we_flag, rq.uf_flag};
            default:   bus_rdata = '0;
        endcase
    end

    assign mode = rq.mode;

    // R2: configuration frozen once locked
    assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rq.locked |=> $stable(rq.mode));

    // R11: events win over a same-cycle clear
    assert_uflow_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_evt |=> rq.uf_flag);

    // R10: refused restart raises the window flag
    assert_winerr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        winerr_evt |=> rq.we_flag);

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_req
);
    localparam int PW = $clog2(LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t pq, pd;

    always_comb begin
        pd = pq;
        if (fire)              pd.left = PW'(LEN);
        else if (pq.left != 0) pd.left = pq.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq <= '0;
        else        pq <= pd;
    end

    assign rst_req = (pq.left != '0);

    // R5: request follows an enabled underflow
    assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rst_req);

    // R6: no request appears without an enabled underflow
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(fire));

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdog_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_en,
    input  logic        dbg_halt_in,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req
);
    wd_mode_t         mode;
    logic             mode_load;
    logic             restart_req;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             uflow_evt;
    logic             winerr_evt;

    assign run = !mode.dis && !(mode.halt_en && dbg_halt_in);

    wdog_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .count       (count),
        .uflow_evt   (uflow_evt),
        .winerr_evt  (winerr_evt),
        .mode        (mode),
        .mode_load   (mode_load),
        .restart_req (restart_req),
        .bus_rdata   (bus_rdata)
    );

    wdog_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_en (slow_en),
        .run     (run),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_dis     (mode.dis),
        .cfg_reload  (mode.reload),
        .cfg_delta   (mode.delta),
        .mode_load   (mode_load),
        .load_value  (bus_wdata[CNT_W-1:0]),
        .restart_req (restart_req),
        .tick        (tick),
        .count       (count),
        .uflow_evt   (uflow_evt),
        .winerr_evt  (winerr_evt)
    );

    wdog_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (uflow_evt && mode.rst_en),
        .rst_req (rst_req)
    );

    // R8: frozen by debug means no tick
    assert_debug_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.halt_en && dbg_halt_in) |-> !tick);

endmodule

// File: tb/wdog_window_top_tb_top.sv
module wdog_window_top_tb_top;

    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        dbg_halt_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    int rst_high = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    wdog_window_top #(.PRESCALE(PRE), .PULSE_LEN(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_en     (slow_en),
        .dbg_halt_in (dbg_halt_in),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .rst_req     (rst_req)
    );

    function automatic logic [31:0] stat(input logic [11:0] c, input logic we, input logic uf);
        return {4'b0, c, 14'b0, we, uf};
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for each read strobe
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd) begin
                if (sb_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL scoreboard actual=read expected=no-read");
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check_eq(it.tag, bus_rdata, it.exp);
                end
            end
            if (rst_req) rst_high++;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_slow(input int n);
        @(negedge clk);
        slow_en = 1'b1;
        repeat (n) @(negedge clk);
        slow_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check_eq("R1 rst_req", {31'b0, rst_req}, 32'd0);
        bus_read(2'd0, 32'h01FF_FFFF, "R1 mode default");
        bus_read(2'd2, stat(12'hFFF, 0, 0), "R1 status default");
        // R10 count equal to delta (0xFFF) is accepted
        bus_write(2'd1, 32'hA500_0001);
        bus_read(2'd2, stat(12'hFFF, 0, 0), "R10 equal delta accepted");

        // R2 first write stored and loads counter
        bus_write(2'd0, 32'h0300_500A);
        bus_read(2'd0, 32'h0300_500A, "R2 first write");
        bus_read(2'd2, stat(12'd10, 0, 0), "R2 load on first write");
        bus_write(2'd0, 32'h00FF_F003);
        bus_read(2'd0, 32'h0300_500A, "R2 second write ignored");
        bus_read(2'd2, stat(12'd10, 0, 0), "R2 count unchanged");

        // R9 bad key / missing bit
        bus_write(2'd1, 32'h5A00_0001);
        bus_read(2'd2, stat(12'd10, 0, 0), "R9 wrong key ignored");
        bus_write(2'd1, 32'hA500_0000);
        bus_read(2'd2, stat(12'd10, 0, 0), "R9 no restart bit ignored");

        // R10 refused above delta, R11 clear on read
        bus_write(2'd1, 32'hA500_0001);
        bus_read(2'd2, stat(12'd10, 1, 0), "R10 window error");
        bus_read(2'd2, stat(12'd10, 0, 0), "R11 flags cleared");

        // R3 / R4 prescale and decrement
        run_slow(16);
        bus_read(2'd2, stat(12'd6, 0, 0), "R4 four ticks");
        run_slow(3);
        bus_read(2'd2, stat(12'd6, 0, 0), "R3 partial period");
        run_slow(1);
        bus_read(2'd2, stat(12'd5, 0, 0), "R3 period boundary");

        // R10 accepted inside window
        bus_write(2'd1, 32'hA500_0001);
        bus_read(2'd2, stat(12'd10, 0, 0), "R10 accepted restart");

        // R8 debug freeze
        dbg_halt_in = 1'b1;
        run_slow(8);
        dbg_halt_in = 1'b0;
        bus_read(2'd2, stat(12'd10, 0, 0), "R8 debug freeze");

        // R4 / R5 underflow with reset
        rst_high = 0;
        run_slow(44);
        repeat (6) @(negedge clk);
        check_eq("R5 pulse length", rst_high, 4);
        bus_read(2'd2, stat(12'd10, 0, 1), "R4 underflow reload and flag");
        bus_read(2'd2, stat(12'd10, 0, 0), "R11 underflow cleared");

        // R7 disabled
        do_reset();
        bus_write(2'd0, 32'h0400_0007);
        rst_high = 0;
        run_slow(40);
        repeat (6) @(negedge clk);
        check_eq("R7 no pulse while disabled", rst_high, 0);
        bus_read(2'd2, stat(12'd7, 0, 0), "R7 count held");
        bus_write(2'd1, 32'hA500_0001);
        bus_read(2'd2, stat(12'd7, 0, 0), "R7 restart ignored");

        // R6 reset disabled
        do_reset();
        bus_write(2'd0, 32'h00FF_F002);
        rst_high = 0;
        run_slow(12);
        repeat (6) @(negedge clk);
        check_eq("R6 no pulse", rst_high, 0);
        bus_read(2'd2, stat(12'd2, 0, 1), "R6 underflow flag");

        @(negedge clk);
        check_eq("scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule